// File: doc/BRIEF.md
# Prioritised Port Pin Multiplexer

This block controls an 8-bit general-purpose I/O port. Software reaches three registers over a simple register bus: an output data register, a direction register and a read-only input register. The input register shows the synchronised state of every pin at all times, so software can read back a pin it is driving and spot a short or an overload.

Pins 3:0 can be taken over by peripherals, and a fixed priority decides which function owns each pin. A primary CAN controller owns pins 1:0. On pins 3:2, a routed second CAN controller comes first, then a routed SPI, and general-purpose I/O comes last. The SPI takes its pins only when it is enabled and is not in bidirectional mode. When a peripheral takes a pin, it sets the pin's drive and output enable. The stored direction bits are never changed by this, so the GPIO setting comes back as soon as the peripheral is disabled. Pins 7:4 are always general-purpose I/O.

Top module: `gpio_pin_arbiter`

## Requirements
- R1: During reset and after it, the data register, the direction register and the input register all read 0x00. Every pin output enable is 0, so every pin is an input.
- R2: The data register (address 0) and the direction register (address 1) can be written and read back at any time. Address 3 reads 0x00.
- R3: The input register (address 2) is read-only. A bus write to address 2 changes no register and does not change what address 2 reads.
- R4: The input register and `pin_sync` show `pin_in` delayed by two clock edges. This holds whatever the pin direction, so a pin driven as an output reads back its pad level. After reset is released, the first pin sample appears at the second rising edge.
- R5: A pin owned by GPIO has output enable equal to its direction bit (1 = output) and drives its data register bit on `pin_out`.
- R6: While `can0_en` is 1, pin 1 is an output driving `can0_tx` and pin 0 is an input. This holds whatever the direction and data registers contain.
- R7: While `can1_en` is 1, pin 3 is an output driving `can1_tx` and pin 2 is an input. This holds whatever the SPI inputs are.
- R8: While `spi_en` is 1, `spi_bidir` is 0 and `can1_en` is 0, pin 2 takes its output enable and value from bit 0 of `spi_oe`/`spi_dout`, and pin 3 takes them from bit 1. While `spi_bidir` is 1, pins 3:2 are under GPIO control.
- R9: Pins 7:4 are always under GPIO control, whatever the peripheral enables are.
- R10: Peripheral overrides never modify the direction register. It changes only through bus writes to address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 data, 1 direction, 2 input |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables, 1 = drive |
| pin_sync | output | 8 | Synchronised pin levels (input register) |
| can0_en | input | 1 | Primary CAN enable |
| can0_tx | input | 1 | Primary CAN transmit value |
| can1_en | input | 1 | Routed CAN enable |
| can1_tx | input | 1 | Routed CAN transmit value |
| spi_en | input | 1 | Routed SPI enable |
| spi_bidir | input | 1 | Routed SPI bidirectional mode |
| spi_oe | input | 2 | SPI output enable for pins 3:2 |
| spi_dout | input | 2 | SPI output values for pins 3:2 |

## Verification
The bench checks the input register one and two edges after reset release and after each pin change. A synchroniser with the wrong depth would show the new value at the one-edge check, or would not show it yet at the two-edge check. The routed CAN is enabled together with a non-bidirectional SPI that drives different values, so a swapped priority would put the SPI's enables on pins 3:2. The SPI is then put into bidirectional mode, and a design that ignored that mode would keep the SPI's values instead of the GPIO ones. After every override the direction register is read back, and a write to the input register is followed by reads of all three registers, so a design that stored overrides or accepted writes to the input register would read back different bytes.

// File: rtl/gpio_pin_arbiter.sv
module gpio_pin_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_sync,
  input  logic       can0_en,
  input  logic       can0_tx,
  input  logic       can1_en,
  input  logic       can1_tx,
  input  logic       spi_en,
  input  logic       spi_bidir,
  input  logic [1:0] spi_oe,
  input  logic [1:0] spi_dout
);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_DIR  = 2'd1;
  localparam logic [1:0] A_IN   = 2'd2;

  logic [7:0] data_q, dir_q, meta_q, sync_q;
  logic       spi_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_DATA) data_q <= bus_wdata;
      if (bus_addr == A_DIR)  dir_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
    end
  end

  assign pin_sync = sync_q;
  assign spi_own  = spi_en && !spi_bidir;

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = data_q;
      A_DIR:   bus_rdata = dir_q;
      A_IN:    bus_rdata = sync_q;
      default: bus_rdata = '0;
    endcase
  end

  always_comb begin
    pin_oe  = dir_q;
    pin_out = data_q;
    if (can0_en) begin
      pin_oe[0]  = 1'b0;
      pin_out[0] = 1'b0;
      pin_oe[1]  = 1'b1;
      pin_out[1] = can0_tx;
    end
    if (can1_en) begin
      pin_oe[2]  = 1'b0;
      pin_out[2] = 1'b0;
      pin_oe[3]  = 1'b1;
      pin_out[3] = can1_tx;
    end else if (spi_own) begin
      pin_oe[3:2]  = spi_oe;
      pin_out[3:2] = spi_dout;
    end
  end
endmodule

// File: rtl/gpio_pin_arbiter_chk.sv
module gpio_pin_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic [7:0] pin_in,
  input logic [7:0] pin_out,
  input logic [7:0] pin_oe,
  input logic [7:0] pin_sync,
  input logic       can0_en,
  input logic       can0_tx,
  input logic       can1_en,
  input logic       can1_tx,
  input logic       spi_en,
  input logic       spi_bidir,
  input logic [1:0] spi_oe,
  input logic [1:0] spi_dout,
  input logic [7:0] dir_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  assert_can0_owns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    can0_en |-> (pin_oe[1:0] == 2'b10) && (pin_out[1] == can0_tx));

  assert_can1_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    can1_en |-> (pin_oe[3:2] == 2'b10) && (pin_out[3] == can1_tx));

  assert_spi_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_en && !spi_bidir && !can1_en) |-> (pin_oe[3:2] == spi_oe) && (pin_out[3:2] == spi_dout));

  assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

  assert_dir_only_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == 2'd1) |=> $stable(dir_q));

  assert_upper_gpio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe[7:4] == dir_q[7:4]);

  assert_reset_inputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (pin_oe == 8'h00) && (pin_sync == 8'h00));
endmodule

bind gpio_pin_arbiter gpio_pin_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_sync(pin_sync),
  .can0_en(can0_en), .can0_tx(can0_tx), .can1_en(can1_en), .can1_tx(can1_tx),
  .spi_en(spi_en), .spi_bidir(spi_bidir), .spi_oe(spi_oe), .spi_dout(spi_dout),
  .dir_q(dir_q)
);

// File: tb/gpio_pin_arbiter_bench.sv
module gpio_pin_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pin_out, pin_oe, pin_sync;
  logic [7:0] pin_in = '0;
  logic can0_en = 0, can0_tx = 0, can1_en = 0, can1_tx = 0;
  logic spi_en = 0, spi_bidir = 0;
  logic [1:0] spi_oe = '0, spi_dout = '0;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  gpio_pin_arbiter u_gpio_pin_arbiter (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    pin_in = 8'hA5;
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R1 data in reset", v, 8'h00);
    rd(2'd1, v); chk("R1 dir in reset", v, 8'h00);
    rd(2'd2, v); chk("R1 input in reset", v, 8'h00);
    chk("R1 oe in reset", pin_oe, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd2, v); chk("R4 one edge after reset", v, 8'h00);
    @(negedge clk);
    rd(2'd2, v); chk("R4 two edges after reset", v, 8'hA5);
    chk("R1 oe after reset", pin_oe, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd0, 8'h3C); wr(2'd1, 8'hC3);
    rd(2'd0, v); chk("R2 data readback", v, 8'h3C);
    rd(2'd1, v); chk("R2 dir readback", v, 8'hC3);
    rd(2'd3, v); chk("R2 unused address", v, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, v); chk("R3 input after write", v, 8'hA5);
    rd(2'd0, v); chk("R3 data untouched", v, 8'h3C);
    rd(2'd1, v); chk("R3 dir untouched", v, 8'hC3);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    wr(2'd1, 8'hFF); wr(2'd0, 8'h5A);
    pin_in = 8'h58;
    @(negedge clk);
    rd(2'd2, v); chk("R4 one edge after change", v, 8'hA5);
    @(negedge clk);
    rd(2'd2, v); chk("R4 output readback", v, 8'h58);
    chk("R4 pin_sync port", pin_sync, 8'h58);
  endtask

  task automatic t_gpio;
    wr(2'd1, 8'h0F); wr(2'd0, 8'hAA);
    #1;
    chk("R5 gpio oe", pin_oe, 8'h0F);
    chk("R5 gpio out", pin_out, 8'hAA);
  endtask

  task automatic t_can0;
    logic [7:0] v;
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    can0_en = 1'b1; can0_tx = 1'b0; #1;
    chk("R6 can0 oe", pin_oe, 8'hFE);
    chk("R6 can0 out", pin_out & 8'h02, 8'h00);
    can0_tx = 1'b1; #1;
    chk("R6 can0 tx follows", pin_out & 8'h02, 8'h02);
    @(negedge clk);
    rd(2'd1, v); chk("R10 dir kept under can0", v, 8'hFF);
    can0_en = 1'b0; #1;
    chk("R10 gpio back after can0", pin_oe, 8'hFF);
  endtask

  task automatic t_spi_can1;
    logic [7:0] v;
    spi_en = 1'b1; spi_bidir = 1'b0; spi_oe = 2'b01; spi_dout = 2'b01;
    can1_en = 1'b1; can1_tx = 1'b1; #1;
    chk("R7 can1 over spi oe", pin_oe & 8'h0C, 8'h08);
    chk("R7 can1 out", pin_out & 8'h08, 8'h08);
    can1_en = 1'b0; #1;
    chk("R8 spi oe", pin_oe & 8'h0C, 8'h04);
    chk("R8 spi out", pin_out & 8'h0C, 8'h04);
    spi_bidir = 1'b1; #1;
    chk("R8 bidir gives gpio oe", pin_oe & 8'h0C, 8'h0C);
    chk("R8 bidir gives gpio out", pin_out & 8'h0C, 8'h0C);
    @(negedge clk);
    rd(2'd1, v); chk("R10 dir kept under spi", v, 8'hFF);
  endtask

  task automatic t_upper;
    can0_en = 1'b1; can1_en = 1'b1; spi_bidir = 1'b0;
    wr(2'd1, 8'h00); wr(2'd0, 8'h00); #1;
    chk("R9 upper oe off", pin_oe & 8'hF0, 8'h00);
    wr(2'd1, 8'hF0); wr(2'd0, 8'h90); #1;
    chk("R9 upper oe on", pin_oe & 8'hF0, 8'hF0);
    chk("R9 upper out", pin_out & 8'hF0, 8'h90);
  endtask

  initial begin
    fork
      begin
        t_reset; t_regs; t_sync; t_gpio; t_can0; t_spi_can1; t_upper;
      end
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule